// File: doc/BRIEF.md
# Conversion Complete Flag Tracker

This block holds one completion flag for each slot of an analog-to-digital conversion sequence. There are sixteen slots by default, and each slot is paired with the result register of the same number. When the sequencer reports that the conversion in slot x has finished, flag x goes high. Flag x stays high until one of two things happens: software starts a new sequence, or software reads result x in the way the clear mode selects.

There are two clear modes. In paired mode, a read of the status register arms every slot whose flag is currently high. A later read of result x then clears flag x and uses up the arm. In fast mode, a read of result x clears flag x with no status read needed. When a clear and a set land on the same flag in the same cycle, the winner depends on the clear source. A sequence-start write beats the set. A read-based clear loses to the set. The block also returns flags 15..8 as a byte on a combinational read port.

Top module: `ccf_tracker`

## Requirements
- R1: After reset, every flag and every arm is 0, and the status byte reads 0x00.
- R2: If bit x of `done_stb` is high at a clock edge, flag x is 1 after that edge. Several bits may be high at once, and each sets its own flag. No flag rises without its strobe.
- R3: A cycle with `seq_start_wr` high clears every flag and every arm at the next edge.
- R4: If `seq_start_wr` and bit x of `done_stb` are high in the same cycle, flag x is 0 after the edge.
- R5: In paired mode (`fast_clr_en`=0), a read of result x clears flag x only if a status read in an earlier cycle, taken while flag x was 1, armed slot x. A result read without that arm leaves the flag unchanged.
- R6: A status read arms exactly the slots whose flag is 1 in that cycle. A flag that is set later stays unarmed. A status read and a result read in the same cycle do not clear the flag being read.
- R7: Any read of result x removes the arm of slot x. A second clear of flag x in paired mode needs a new status read.
- R8: In fast mode (`fast_clr_en`=1), a read of result x clears flag x with no status read needed.
- R9: If a read-based clear of flag x (in either mode) and bit x of `done_stb` fall in the same cycle, flag x is 1 after the edge.
- R10: `stat_rdata` bits 7..0 always equal flags 15..8. The value is combinational, so it shows the flags before any clear caused by the same cycle's reads. Writes to the status register (`stat_wr`, `stat_wdata`) change no flag.
- R11: A result read whose 5-bit index is 16 or above clears no flag and no arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_stb | input | 16 | One bit per slot: the conversion in that slot finished this cycle |
| seq_start_wr | input | 1 | Write to the sequence-start control register |
| fast_clr_en | input | 1 | 1 selects fast clear; 0 selects status-then-result clear |
| stat_rd | input | 1 | Single-cycle read strobe of the status register |
| stat_wr | input | 1 | Write strobe to the status register (ignored) |
| stat_wdata | input | 8 | Write data for the status register (ignored) |
| res_rd | input | 1 | Single-cycle read strobe of a result register |
| res_idx | input | 5 | Index of the result register being read |
| flags | output | 16 | Current completion flags |
| stat_rdata | output | 8 | Flags 15..8 as the status read-back byte |

## Verification
The bench drives every same-cycle collision in both clear modes and checks the flags after each one:
- A design that gave the set priority over a sequence-start write would leave a stale flag high.
- A design that gave a read-based clear priority over a set would lose a completion.

For arming, the bench covers three cases:
- a status read and a result read in the same cycle;
- a flag that rises after the status read;
- a second result read that reuses an arm already consumed.

A design that armed every slot, or never consumed its arms, would clear flags that should stay high. Result indices 16 to 31 are also driven, with index 24 chosen on purpose: a decoder that drops the top index bit would alias that read onto slot 8 and clear it.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
    parameter int unsigned CCF_DEF_POS = 16;
    parameter int unsigned CCF_DEF_IDX_W = 5;

    typedef enum logic {
        CLR_PAIRED = 1'b0,
        CLR_FAST   = 1'b1
    } ccf_clr_mode_e;
endpackage

// File: rtl/ccf_index_decode.sv
module ccf_index_decode #(
    parameter int unsigned NUM_POS = 16,
    parameter int unsigned IDX_W   = 5
) (
    input  logic               res_rd,
    input  logic [IDX_W-1:0]   res_idx,
    output logic [NUM_POS-1:0] res_hit
);
    // One comparator per slot; the full index width is compared so
    // out-of-range indices hit nothing.
    for (genvar gi = 0; gi < NUM_POS; gi++) begin : g_hit
        assign res_hit[gi] = res_rd && (res_idx == IDX_W'(gi));
    end

    always_comb begin
        assert ($onehot0(res_hit)) else $error("decode hit more than one slot");
    end
endmodule

// File: rtl/ccf_clear_select.sv
module ccf_clear_select
    import ccf_pkg::*;
#(
    parameter int unsigned NUM_POS = 16
) (
    input  ccf_clr_mode_e      mode,
    input  logic [NUM_POS-1:0] res_hit,
    input  logic [NUM_POS-1:0] armed,
    output logic [NUM_POS-1:0] rd_clr
);
    for (genvar gi = 0; gi < NUM_POS; gi++) begin : g_clr
        always_comb begin
            unique case (mode)
                CLR_FAST:   rd_clr[gi] = res_hit[gi];
                CLR_PAIRED: rd_clr[gi] = res_hit[gi] && armed[gi];
                default:    rd_clr[gi] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ccf_arm_track.sv
module ccf_arm_track #(
    parameter int unsigned NUM_POS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seq_clr,
    input  logic               stat_rd,
    input  logic [NUM_POS-1:0] flags_cur,
    input  logic [NUM_POS-1:0] res_hit,
    output logic [NUM_POS-1:0] armed
);
    typedef struct packed {
        logic [NUM_POS-1:0] arm;
    } arm_state_t;

    arm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (seq_clr) begin
            st_d.arm = '0;
        end else begin
            // New arms come from flags set now; any result read disarms its slot.
            st_d.arm = (st_q.arm | (stat_rd ? flags_cur : '0)) & ~res_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.arm;

    // An armed slot always has its flag high (arms are only taken from set flags).
    assert_armed_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.arm & ~flags_cur) == '0));

    // A result read consumes the arm of that slot.
    assert_arm_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.arm & $past(res_hit)) == '0));

    assert_seq_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr |=> (st_q.arm == '0));
endmodule

// File: rtl/ccf_tracker.sv
module ccf_tracker
    import ccf_pkg::*;
#(
    parameter int unsigned NUM_POS  = CCF_DEF_POS,
    parameter int unsigned IDX_W    = CCF_DEF_IDX_W,
    parameter int unsigned RDBK_LO  = 8,
    parameter int unsigned RDBK_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_POS-1:0] done_stb,
    input  logic               seq_start_wr,
    input  logic               fast_clr_en,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [RDBK_W-1:0]  stat_wdata,
    input  logic               res_rd,
    input  logic [IDX_W-1:0]   res_idx,
    output logic [NUM_POS-1:0] flags,
    output logic [RDBK_W-1:0]  stat_rdata
);
    localparam int unsigned RDBK_HI = RDBK_LO + RDBK_W;

    initial begin
        assert (RDBK_HI <= NUM_POS) else $error("read-back window exceeds slot count");
        assert ((1 << IDX_W) >= NUM_POS) else $error("result index too narrow");
    end

    typedef struct packed {
        logic [NUM_POS-1:0] flg;
    } flag_state_t;

    flag_state_t   st_d, st_q;
    ccf_clr_mode_e mode;
    logic [NUM_POS-1:0] res_hit;
    logic [NUM_POS-1:0] armed;
    logic [NUM_POS-1:0] rd_clr;

    // Status-register writes have no effect; the inputs end here.
    logic unused_stat_wr_sink;
    assign unused_stat_wr_sink = stat_wr ^ (^stat_wdata);

    assign mode = ccf_clr_mode_e'(fast_clr_en);

    ccf_index_decode #(
        .NUM_POS (NUM_POS),
        .IDX_W   (IDX_W)
    ) u_decode (
        .res_rd  (res_rd),
        .res_idx (res_idx),
        .res_hit (res_hit)
    );

    ccf_arm_track #(
        .NUM_POS (NUM_POS)
    ) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_clr   (seq_start_wr),
        .stat_rd   (stat_rd),
        .flags_cur (st_q.flg),
        .res_hit   (res_hit),
        .armed     (armed)
    );

    ccf_clear_select #(
        .NUM_POS (NUM_POS)
    ) u_clrsel (
        .mode    (mode),
        .res_hit (res_hit),
        .armed   (armed),
        .rd_clr  (rd_clr)
    );

    always_comb begin
        st_d = st_q;
        if (seq_start_wr) begin
            // Sequence start overrides any completion in the same cycle.
            st_d.flg = '0;
        end else begin
            // A completion overrides a read-based clear.
            st_d.flg = (st_q.flg & ~rd_clr) | done_stb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags      = st_q.flg;
    assign stat_rdata = st_q.flg[RDBK_LO +: RDBK_W];

    assert_seq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_wr |=> (flags == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_start_wr |=> ((flags & $past(done_stb)) == $past(done_stb)));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(done_stb)) == '0));

    assert_one_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_start_wr |=> ($countones($past(flags) & ~flags) <= 1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_start_wr && (!res_rd || res_idx >= IDX_W'(NUM_POS))) |=> (flags == ($past(flags) | $past(done_stb))));
endmodule

// File: tb/ccf_tracker_test.sv
module ccf_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] done_stb = '0;
    logic        seq_start_wr = 1'b0;
    logic        fast_clr_en = 1'b0;
    logic        stat_rd = 1'b0;
    logic        stat_wr = 1'b0;
    logic [7:0]  stat_wdata = '0;
    logic        res_rd = 1'b0;
    logic [4:0]  res_idx = '0;
    logic [15:0] flags;
    logic [7:0]  stat_rdata;

    int checks = 0;
    int failures = 0;
    bit [15:0] m_flag = '0;
    bit [15:0] m_arm = '0;

    always #4 clk = ~clk;

    ccf_tracker uut (
        .clk(clk), .rst_n(rst_n), .done_stb(done_stb), .seq_start_wr(seq_start_wr),
        .fast_clr_en(fast_clr_en), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .res_rd(res_rd), .res_idx(res_idx),
        .flags(flags), .stat_rdata(stat_rdata)
    );

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: applies the priority rules of the requirements.
    task automatic model_edge();
        bit [15:0] nf, na;
        for (int i = 0; i < 16; i++) begin
            bit hit, clr;
            hit = res_rd && (int'(res_idx) == i);
            clr = hit && (fast_clr_en || m_arm[i]);
            if (seq_start_wr) begin
                nf[i] = 1'b0;
                na[i] = 1'b0;
            end else begin
                nf[i] = (m_flag[i] && !clr) || done_stb[i];
                na[i] = (m_arm[i] || (stat_rd && m_flag[i])) && !hit;
            end
        end
        m_flag = nf;
        m_arm  = na;
    endtask

    task automatic step(string tag, logic [15:0] d, logic sq, logic sr,
                        logic rr, logic [4:0] ri, logic sw = 1'b0, logic [7:0] swd = 8'h00);
        @(negedge clk);
        done_stb = d; seq_start_wr = sq; stat_rd = sr; res_rd = rr; res_idx = ri;
        stat_wr = sw; stat_wdata = swd;
        #1;
        check16({tag, " R10 status byte"}, {8'h00, stat_rdata}, {8'h00, m_flag[15:8]});
        @(posedge clk);
        model_edge();
        #1;
        check16({tag, " flags"}, flags, m_flag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step("IDLE", '0, 0, 0, 0, 5'd0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check16("R1 reset flags", flags, 16'h0000);
        check16("R1 reset byte", {8'h00, stat_rdata}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: several slots at once
        step("R2 set 0,8,15", 16'h8101, 0, 0, 0, 5'd0);
        check16("R2 explicit", flags, 16'h8101);
        step("R2 set 3", 16'h0008, 0, 0, 0, 5'd0);
        // R10: writes ignored
        step("R10 write ff", '0, 0, 0, 0, 5'd0, 1'b1, 8'hFF);
        step("R10 write 00", '0, 0, 0, 0, 5'd0, 1'b1, 8'h00);
        check16("R10 write ignored", flags, 16'h8109);
        // R5: unarmed read does not clear in paired mode
        step("R5 unarmed rd8", '0, 0, 0, 1, 5'd8);
        check16("R5 unarmed stays", flags, 16'h8109);
        // R6: status + result same cycle
        step("R6 stat+rd3 same", '0, 0, 1, 1, 5'd3);
        check16("R6 same cycle no clear", flags, 16'h8109);
        step("R6 set 4 after arm", 16'h0010, 0, 0, 0, 5'd0);
        step("R6 rd4 unarmed", '0, 0, 0, 1, 5'd4);
        check16("R6 late flag stays", flags, 16'h8119);
        step("R5 rd8 armed", '0, 0, 0, 1, 5'd8);
        check16("R5 armed clear", flags, 16'h8019);
        // R7: arm consumed
        step("R7 reset 8", 16'h0100, 0, 0, 0, 5'd0);
        step("R7 rd8 again", '0, 0, 0, 1, 5'd8);
        check16("R7 arm consumed", flags, 16'h8119);
        // R11: out of range index, 24 aliases 8 if truncated
        step("R11 arm", '0, 0, 1, 0, 5'd0);
        step("R11 rd24", '0, 0, 0, 1, 5'd24);
        step("R11 rd31", '0, 0, 0, 1, 5'd31);
        check16("R11 no clear", flags, 16'h8119);
        step("R11 rd8 still armed", '0, 0, 0, 1, 5'd8);
        check16("R11 arm kept", flags, 16'h8019);
        // R9 paired: armed clear vs set
        step("R9 rd15+set15", 16'h8000, 0, 0, 1, 5'd15);
        check16("R9 paired set wins", flags, 16'h8019);
        // R3 / R4
        step("R4 seq+set2", 16'h0004, 1, 0, 0, 5'd0);
        check16("R4 clear wins", flags, 16'h0000);
        step("R3 set 9", 16'h0200, 0, 0, 0, 5'd0);
        step("R3 arm 9", '0, 0, 1, 0, 5'd0);
        step("R3 seq", '0, 1, 0, 0, 5'd0);
        step("R3 set 9 again", 16'h0200, 0, 0, 0, 5'd0);
        step("R3 rd9 disarmed", '0, 0, 0, 1, 5'd9);
        check16("R3 arms cleared", flags, 16'h0200);
        // R8 fast mode
        fast_clr_en = 1'b1;
        step("R8 fast rd9", '0, 0, 0, 1, 5'd9);
        check16("R8 fast clear", flags, 16'h0000);
        step("R8 set 12", 16'h1000, 0, 0, 0, 5'd0);
        step("R9 fast rd12+set12", 16'h1000, 0, 0, 1, 5'd12);
        check16("R9 fast set wins", flags, 16'h1000);
        step("R4 fast seq+set", 16'h1001, 1, 0, 1, 5'd12);
        check16("R4 fast clear wins", flags, 16'h0000);

        // Mixed stimulus in both modes against the model
        for (int n = 0; n < 600; n++) begin
            logic [15:0] d;
            d = 16'($urandom) & 16'($urandom) & 16'($urandom);
            if (n % 150 == 0) fast_clr_en = ~fast_clr_en;
            step("MIX R2 R5 R8 R9", d, ($urandom % 40) == 0, ($urandom % 4) == 0,
                 ($urandom % 2) == 0, 5'($urandom));
        end
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule